// File: doc/BRIEF.md
# Seat-Belt Reminder Alarm Controller

This block decides when a seat-belt reminder should sound. A three-state control machine (idle, grace, sounding) runs in lock-step with a seconds timer. Both change state on the same clock edge, and together they form one synchronous product. The inputs are single-cycle event pulses: ignition turned on, ignition turned off, belt latched, and a one-second tick that arrives from outside the block.

When the ignition turns on, the controller strobes the timer's start input in the same cycle and enters a grace period. If the belt is still open when the timer reports five seconds, the controller pulses alarm-on and sounds the reminder. The reminder stops, with an alarm-off pulse, on whichever comes first: the ten-second report, the belt latching, or the ignition turning off.

The start strobe, the alarm-on pulse and the alarm-off pulse are combinational responses to the current inputs and state. The alarm level is a registered output.

Top module: `sbr_alarm_top`

## Requirements
- R1: After synchronous reset the controller is idle, the timer is stopped, `alarm_o` is low and no strobe is asserted.
- R2: In idle, an `ign_on_i` pulse asserts `start_timer_o` in the same cycle, and the controller is in grace from the next cycle.
- R3: In grace, `ign_off_i` or `belt_lock_i` returns the controller to idle with neither alarm pulse. Both together in one cycle have the same effect as either alone.
- R4: In grace, the fifth `sec_tick_i` after the last start strobe asserts `alarm_on_o` in that cycle, and `alarm_o` is high from the next cycle.
- R5: In sounding, the tenth tick after the last start, `belt_lock_i` or `ign_off_i` asserts `alarm_off_o` in that cycle, and `alarm_o` is low from the next cycle.
- R6: The timer advances only on cycles with `sec_tick_i` high. Cycles without a tick do not count.
- R7: A start strobe while the timer is already running restarts the count from zero.
- R8: Timer end reports that arrive while the controller is idle have no effect: no alarm pulse and `alarm_o` stays low.
- R9: `alarm_o` is registered and is high exactly while the controller is in the sounding state.
- R10: `ign_on_i` in grace or sounding produces no start strobe and does not restart the timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ign_on_i | input | 1 | Ignition-on event pulse |
| ign_off_i | input | 1 | Ignition-off event pulse |
| belt_lock_i | input | 1 | Belt-latched event pulse |
| sec_tick_i | input | 1 | One-second tick pulse |
| start_timer_o | output | 1 | Start strobe, also wired to the timer |
| alarm_on_o | output | 1 | Pulse when the reminder starts |
| alarm_off_o | output | 1 | Pulse when the reminder stops |
| alarm_o | output | 1 | Registered reminder level |

## Verification
The hardest case to reach from the ports is a timer report that arrives while the controller is already idle. It can only happen if the ignition turns off or the belt latches partway through a count, which leaves the timer running on its own. The bench therefore abandons the grace period after a few ticks and keeps ticking past the five- and ten-second marks, checking that no pulse appears. It reaches the restart case in a similar way: it turns the ignition off and on again while the timer is still running, then counts the ticks to the alarm from the second start.

// File: rtl/sbr_pkg.sv
package sbr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_GRACE = 2'd1,
        ST_SOUND = 2'd2
    } sbr_state_e;

    typedef struct packed {
        logic ign_on;
        logic ign_off;
        logic belt_lock;
    } sbr_evt_t;

    function automatic logic sbr_cancel(input sbr_evt_t e);
        return e.ign_off | e.belt_lock;
    endfunction

    function automatic int unsigned sbr_cnt_width(input int unsigned limit);
        return (limit < 2) ? 1 : $clog2(limit + 1);
    endfunction

endpackage

// File: rtl/sbr_sec_timer.sv
module sbr_sec_timer
    import sbr_pkg::*;
#(
    parameter int unsigned WARN_SECS  = 5,
    parameter int unsigned LIMIT_SECS = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    input  logic tick_i,
    output logic warn_end_o,
    output logic limit_end_o
);
    localparam int unsigned CNT_W = sbr_cnt_width(LIMIT_SECS);
    localparam logic [CNT_W-1:0] WARN_LAST  = CNT_W'(WARN_SECS - 1);
    localparam logic [CNT_W-1:0] LIMIT_LAST = CNT_W'(LIMIT_SECS - 1);

    logic             run_q;
    logic [CNT_W-1:0] cnt_q;
    logic             advance;

    // A start strobe has priority over a tick in the same cycle.
    assign advance     = run_q & tick_i & ~start_i;
    assign warn_end_o  = advance & (cnt_q == WARN_LAST);
    assign limit_end_o = advance & (cnt_q == LIMIT_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= 1'b0;
            cnt_q <= '0;
        end else if (start_i) begin
            run_q <= 1'b1;
            cnt_q <= '0;
        end else if (advance) begin
            if (cnt_q == LIMIT_LAST) begin
                run_q <= 1'b0;
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // R7: a start always leaves the timer running from zero
    assert_restart_clears_R7: assert property (@(posedge clk) disable iff (rst)
        start_i |=> (run_q && cnt_q == '0));

    // R6: the count holds on cycles with no tick and no start
    assert_hold_without_tick_R6: assert property (@(posedge clk) disable iff (rst)
        (!tick_i && !start_i) |=> ($stable(cnt_q) && $stable(run_q)));

    // the limit report retires the timer
    assert_limit_stops_R5: assert property (@(posedge clk) disable iff (rst)
        (limit_end_o && !start_i) |=> !run_q);

endmodule

// File: rtl/sbr_ctrl_fsm.sv
module sbr_ctrl_fsm
    import sbr_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  sbr_evt_t evt_i,
    input  logic     warn_end_i,
    input  logic     limit_end_i,
    output logic     start_o,
    output logic     alarm_on_o,
    output logic     alarm_off_o,
    output logic     alarm_o
);
    sbr_state_e state_q, state_d;
    logic       alarm_q;

    always_comb begin
        state_d     = state_q;
        start_o     = 1'b0;
        alarm_on_o  = 1'b0;
        alarm_off_o = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (evt_i.ign_on) begin
                    start_o = 1'b1;
                    state_d = ST_GRACE;
                end
            end
            ST_GRACE: begin
                if (sbr_cancel(evt_i)) begin
                    state_d = ST_IDLE;
                end else if (warn_end_i) begin
                    alarm_on_o = 1'b1;
                    state_d    = ST_SOUND;
                end
            end
            ST_SOUND: begin
                if (sbr_cancel(evt_i) || limit_end_i) begin
                    alarm_off_o = 1'b1;
                    state_d     = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            alarm_q <= 1'b0;
        end else begin
            state_q <= state_d;
            alarm_q <= (state_d == ST_SOUND);
        end
    end

    assign alarm_o = alarm_q;

    // R2: the start strobe leads into the grace state
    assert_start_enters_grace_R2: assert property (@(posedge clk) disable iff (rst)
        start_o |=> (state_q == ST_GRACE));

    // R4: alarm-on is followed by a high level
    assert_on_raises_level_R4: assert property (@(posedge clk) disable iff (rst)
        alarm_on_o |=> alarm_o);

    // R5: alarm-off is followed by a low level
    assert_off_drops_level_R5: assert property (@(posedge clk) disable iff (rst)
        alarm_off_o |=> !alarm_o);

    // R8: timer reports seen in idle never lead to sounding
    assert_idle_ignores_end_R8: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && (warn_end_i || limit_end_i)) |=> (state_q != ST_SOUND));

    // R9: the level follows the sounding state
    assert_level_tracks_state_R9: assert property (@(posedge clk) disable iff (rst)
        alarm_o == (state_q == ST_SOUND));

endmodule

// File: rtl/sbr_alarm_top.sv
module sbr_alarm_top
    import sbr_pkg::*;
#(
    parameter int unsigned WARN_SECS  = 5,
    parameter int unsigned LIMIT_SECS = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic ign_on_i,
    input  logic ign_off_i,
    input  logic belt_lock_i,
    input  logic sec_tick_i,
    output logic start_timer_o,
    output logic alarm_on_o,
    output logic alarm_off_o,
    output logic alarm_o
);
    sbr_evt_t evt;
    logic     start_w;
    logic     warn_end_w;
    logic     limit_end_w;

    assign evt = '{ign_on: ign_on_i, ign_off: ign_off_i, belt_lock: belt_lock_i};

    sbr_ctrl_fsm u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .evt_i       (evt),
        .warn_end_i  (warn_end_w),
        .limit_end_i (limit_end_w),
        .start_o     (start_w),
        .alarm_on_o  (alarm_on_o),
        .alarm_off_o (alarm_off_o),
        .alarm_o     (alarm_o)
    );

    sbr_sec_timer #(
        .WARN_SECS  (WARN_SECS),
        .LIMIT_SECS (LIMIT_SECS)
    ) u_timer (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start_w),
        .tick_i      (sec_tick_i),
        .warn_end_o  (warn_end_w),
        .limit_end_o (limit_end_w)
    );

    assign start_timer_o = start_w;

    // R9: a rising level is always announced by alarm-on
    assert_level_rise_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(alarm_o) |-> $past(alarm_on_o));

    // R10: no start strobe while the reminder is sounding
    assert_no_start_sounding_R10: assert property (@(posedge clk) disable iff (rst)
        alarm_o |-> !start_timer_o);

    // the two reminder pulses never coincide
    assert_pulses_exclusive_R4: assert property (@(posedge clk) disable iff (rst)
        !(alarm_on_o && alarm_off_o));

endmodule

// File: tb/sbr_alarm_top_bench.sv
`timescale 1ns/1ps
module sbr_alarm_top_bench;
    localparam int WARN  = 5;
    localparam int LIMIT = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ign_on = 1'b0, ign_off = 1'b0, belt = 1'b0, tick = 1'b0;
    logic start_timer, alarm_on, alarm_off, alarm;

    always #2.5 clk = ~clk;

    sbr_alarm_top #(.WARN_SECS(WARN), .LIMIT_SECS(LIMIT)) u_sbr_alarm_top (
        .clk(clk), .rst(rst),
        .ign_on_i(ign_on), .ign_off_i(ign_off), .belt_lock_i(belt), .sec_tick_i(tick),
        .start_timer_o(start_timer), .alarm_on_o(alarm_on),
        .alarm_off_o(alarm_off), .alarm_o(alarm)
    );

    typedef struct {
        logic  st;
        logic  on;
        logic  off;
        logic  lvl;
        string tag;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0;
    int   fails  = 0;
    bit   done   = 1'b0;

    // requirement-level model state
    int m_state = 0;   // 0 idle, 1 grace, 2 sounding
    bit m_run   = 1'b0;
    int m_cnt   = 0;

    task automatic step(input logic kon, input logic koff, input logic blt,
                        input logic tk, input string tag);
        exp_t e;
        bit   st, adv, e5, e10;
        int   nxt;
        @(negedge clk);
        ign_on = kon; ign_off = koff; belt = blt; tick = tk;
        st  = kon && (m_state == 0);
        adv = m_run && tk && !st;
        e5  = adv && (m_cnt == WARN - 1);
        e10 = adv && (m_cnt == LIMIT - 1);
        e.st = st; e.on = 1'b0; e.off = 1'b0;
        e.lvl = (m_state == 2);
        e.tag = tag;
        nxt = m_state;
        case (m_state)
            0: if (kon) nxt = 1;
            1: if (koff || blt) nxt = 0;
               else if (e5) begin nxt = 2; e.on = 1'b1; end
            default: if (e10 || koff || blt) begin nxt = 0; e.off = 1'b1; end
        endcase
        m_state = nxt;
        if (st) begin m_run = 1'b1; m_cnt = 0; end
        else if (adv) begin
            if (m_cnt == LIMIT - 1) begin m_run = 1'b0; m_cnt = 0; end
            else m_cnt = m_cnt + 1;
        end
        exp_q.push_back(e);
    endtask

    task automatic ticks(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            step(0, 0, 0, 1, tag);
            step(0, 0, 0, 0, tag);   // quiet cycle between ticks
        end
    endtask

    // monitor: compares each driven cycle against the scoreboard
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                checks++;
                if ({start_timer, alarm_on, alarm_off, alarm} !== {e.st, e.on, e.off, e.lvl}) begin
                    fails++;
                    $display("FAIL %s: start/on/off/level actual=%b%b%b%b expected=%b%b%b%b",
                             e.tag, start_timer, alarm_on, alarm_off, alarm,
                             e.st, e.on, e.off, e.lvl);
                end
            end
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #2;
        checks++;   // R1 reset state
        if ({start_timer, alarm_on, alarm_off, alarm} !== 4'b0000) begin
            fails++;
            $display("FAIL R1: outputs in reset actual=%b%b%b%b expected=0000",
                     start_timer, alarm_on, alarm_off, alarm);
        end
        @(negedge clk);
        rst = 1'b0;
        step(0, 0, 0, 1, "R1");      // tick with no start: nothing happens

        // full reminder ending on the ten-second report
        step(1, 0, 0, 0, "R2");
        ticks(4, "R6");
        step(0, 0, 0, 1, "R4");      // fifth tick
        step(0, 0, 0, 0, "R9");
        ticks(4, "R9");
        step(0, 0, 0, 1, "R5");      // tenth tick
        step(0, 0, 0, 0, "R5");

        // belt during grace, then timer reports arrive while idle
        step(1, 0, 0, 0, "R2");
        ticks(2, "R6");
        step(0, 0, 1, 0, "R3");
        ticks(8, "R8");
        step(0, 0, 0, 0, "R8");

        // both cancel events together
        step(1, 0, 0, 0, "R2");
        step(0, 1, 1, 0, "R3");
        step(0, 0, 0, 0, "R3");

        // restart while the timer is running
        step(1, 0, 0, 0, "R2");
        ticks(2, "R7");
        step(0, 1, 0, 0, "R3");
        step(1, 0, 0, 0, "R7");
        ticks(4, "R7");
        step(0, 0, 0, 1, "R7");      // fifth tick after restart
        step(0, 1, 0, 0, "R5");      // ignition off while sounding
        step(0, 0, 0, 0, "R5");

        // ignition-on during grace and sounding is ignored
        step(1, 0, 0, 0, "R2");
        step(0, 0, 0, 1, "R10");
        step(1, 0, 0, 0, "R10");
        ticks(3, "R10");
        step(0, 0, 0, 1, "R10");     // fifth tick from the first start
        step(1, 0, 0, 0, "R10");
        step(0, 0, 1, 0, "R5");      // belt while sounding
        step(0, 0, 0, 0, "R9");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule